// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block watches a free-running 16-bit timer value and compares it each clock cycle with a programmable 16-bit compare register. When the timer reaches the compare value, a 4-bit mode field decides the reaction. The unit can set its output pin, clear its output pin, only raise the interrupt flag, or issue a special event. A special event pulses a timer-clear request, so the compare value becomes the timer's period. The same event can also strobe an A/D conversion start when the converter is enabled.

Software loads the compare value and the mode through two write strobes. The timer, the converter and the interrupt controller are outside this block. The interrupt flag stays set until software clears it. The pin only follows a match while its output enable is asserted.

Top module: `cmp_evt_unit`

## Requirements
- R1: After reset, `cmp_pin`, `irq_flag`, `tmr_rst` and `adc_start` are all 0, the compare register is 0 and the mode is 4'h0.
- R2: A match event happens in a cycle where `tmr_val` equals the compare register and did not equal it in the previous cycle. While the equality holds, no further event is produced.
- R3: In mode 4'b1000, a match with `pin_oe` high sets `cmp_pin` to 1 from the next clock edge.
- R4: In mode 4'b1001, a match with `pin_oe` high clears `cmp_pin` to 0 from the next clock edge.
- R5: In mode 4'b1010, a match sets `irq_flag` and leaves `cmp_pin` unchanged.
- R6: In mode 4'b1011, a match produces a one-cycle `tmr_rst` pulse in the cycle after the match and leaves `cmp_pin` unchanged.
- R7: `adc_start` pulses together with `tmr_rst`, but only if `adc_en` was high in the match cycle.
- R8: Modes whose upper two bits are not 2'b10 disable the unit. A match in such a mode changes neither the flag, the pin nor the trigger outputs.
- R9: A match in any of the four active modes sets `irq_flag`. The flag stays set until `flag_clr` is pulsed. A clear in the same cycle as a match leaves the flag set.
- R10: While `pin_oe` is low, a match leaves `cmp_pin` unchanged.
- R11: A mode write forces `cmp_pin` to 0 for mode 4'b1000 and to 1 for mode 4'b1001, and leaves it unchanged for other modes. If a mode write and a match fall in the same cycle, the mode write decides the pin. The flag and trigger outputs follow the mode that was in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| val_wr | input | 1 | Strobe that loads `val_data` into the compare register |
| val_data | input | 16 | New compare value |
| mode_wr | input | 1 | Strobe that loads `mode_data` into the mode field |
| mode_data | input | 4 | New mode |
| tmr_val | input | 16 | Current timer value |
| adc_en | input | 1 | Converter enabled; gates `adc_start` |
| pin_oe | input | 1 | Allows a match to change the pin |
| flag_clr | input | 1 | Software clear of the interrupt flag |
| cmp_pin | output | 1 | Compare output pin |
| irq_flag | output | 1 | Sticky interrupt flag |
| tmr_rst | output | 1 | One-cycle timer clear request |
| adc_start | output | 1 | One-cycle conversion start strobe |

## Verification
Two pairs of functions can collide in one cycle.

The first pair is the flag: a software clear can land on the same edge as a new match. The bench provokes this with a directed sequence, where the clear is pulsed exactly in the cycle the timer first equals the compare value. Random stimulus then repeats the collision at a high clear rate. The flag must still read 1 afterwards.

The second pair is the pin: a mode write can arrive in the same cycle as a match. The bench judges this case against its own model, in which the mode write decides the pin and the old mode decides the flag and the triggers.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int TMR_W  = 16;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MD_SET  = 4'b1000;
  localparam logic [MODE_W-1:0] MD_CLR  = 4'b1001;
  localparam logic [MODE_W-1:0] MD_SWI  = 4'b1010;
  localparam logic [MODE_W-1:0] MD_SPEC = 4'b1011;

  // a mode is active when its upper two bits are 2'b10
  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    return m[MODE_W-1:MODE_W-2] == 2'b10;
  endfunction

  // pin value after a match under mode m
  function automatic logic pin_after_match(input logic [MODE_W-1:0] m, input logic cur);
    if (m == MD_SET) return 1'b1;
    if (m == MD_CLR) return 1'b0;
    return cur;
  endfunction

  // pin value after a write of mode m
  function automatic logic pin_after_mode_wr(input logic [MODE_W-1:0] m, input logic cur);
    if (m == MD_SET) return 1'b0;
    if (m == MD_CLR) return 1'b1;
    return cur;
  endfunction
endpackage

// File: rtl/cmp_match_det.sv
module cmp_match_det #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tmr,
  input  logic [W-1:0] cmp,
  output logic         match_evt
);
  logic eq_now, eq_q;

  assign eq_now    = (tmr == cmp);
  assign match_evt = eq_now && !eq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq_now;
  end

  // R2
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> !match_evt);
endmodule

// File: rtl/cmp_pin_ctl.sv
module cmp_pin_ctl
  import cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match_evt,
  input  logic [MODE_W-1:0] mode_cur,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_new,
  input  logic              oe,
  output logic              pin
);
  logic pin_q, pin_d;

  always_comb begin
    pin_d = pin_q;
    if (mode_wr)
      pin_d = pin_after_mode_wr(mode_new, pin_q);
    else if (match_evt && oe && mode_active(mode_cur))
      pin_d = pin_after_match(mode_cur, pin_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;

  // R10
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !oe && !mode_wr) |=> $stable(pin));
  // R11
  init_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_new == MD_SET) |=> !pin);
  // R5
  swi_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode_cur == MD_SWI && !mode_wr) |=> $stable(pin));
endmodule

// File: rtl/cmp_flag_ctl.sv
module cmp_flag_ctl
  import cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match_evt,
  input  logic [MODE_W-1:0] mode_cur,
  input  logic              adc_en,
  input  logic              flag_clr,
  output logic              flag,
  output logic              tmr_rst,
  output logic              adc_start
);
  logic act, spec_hit;

  assign act      = match_evt && mode_active(mode_cur);
  assign spec_hit = act && (mode_cur == MD_SPEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag      <= 1'b0;
      tmr_rst   <= 1'b0;
      adc_start <= 1'b0;
    end else begin
      if (act)           flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      tmr_rst   <= spec_hit;
      adc_start <= spec_hit && adc_en;
    end
  end

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> flag);
  // R7
  adc_with_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> tmr_rst);
  // R6
  rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rst |=> !tmr_rst);
  // R8
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_active(mode_cur) && !flag && !flag_clr) |=> !flag && !tmr_rst);
endmodule

// File: rtl/cmp_evt_unit.sv
module cmp_evt_unit
  import cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              val_wr,
  input  logic [TMR_W-1:0]  val_data,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_data,
  input  logic [TMR_W-1:0]  tmr_val,
  input  logic              adc_en,
  input  logic              pin_oe,
  input  logic              flag_clr,
  output logic              cmp_pin,
  output logic              irq_flag,
  output logic              tmr_rst,
  output logic              adc_start
);
  logic [TMR_W-1:0]  cmp_q;
  logic [MODE_W-1:0] mode_q;
  logic              match_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      mode_q <= '0;
    end else begin
      if (val_wr)  cmp_q  <= val_data;
      if (mode_wr) mode_q <= mode_data;
    end
  end

  cmp_match_det #(.W(TMR_W)) u_match (
    .clk(clk), .rst_n(rst_n), .tmr(tmr_val), .cmp(cmp_q), .match_evt(match_evt)
  );

  cmp_pin_ctl u_pin (
    .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .mode_cur(mode_q),
    .mode_wr(mode_wr), .mode_new(mode_data), .oe(pin_oe), .pin(cmp_pin)
  );

  cmp_flag_ctl u_flag (
    .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .mode_cur(mode_q),
    .adc_en(adc_en), .flag_clr(flag_clr), .flag(irq_flag),
    .tmr_rst(tmr_rst), .adc_start(adc_start)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !cmp_pin && !irq_flag && !tmr_rst && !adc_start);
endmodule

// File: tb/tb_cmp_evt_unit.sv
`timescale 1ns/1ps
module tb_cmp_evt_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        val_wr, mode_wr, adc_en, pin_oe, flag_clr;
  logic [15:0] val_data, tmr_val;
  logic [3:0]  mode_data;
  logic        cmp_pin, irq_flag, tmr_rst, adc_start;

  int total = 0;
  int bad = 0;

  // bench model state
  logic [15:0] m_val;
  logic [3:0]  m_mode;
  logic        m_eqp, m_pin, m_flag, m_tr, m_adc;

  always #2.5 clk = ~clk;

  cmp_evt_unit dut (
    .clk(clk), .rst_n(rst_n), .val_wr(val_wr), .val_data(val_data),
    .mode_wr(mode_wr), .mode_data(mode_data), .tmr_val(tmr_val),
    .adc_en(adc_en), .pin_oe(pin_oe), .flag_clr(flag_clr),
    .cmp_pin(cmp_pin), .irq_flag(irq_flag), .tmr_rst(tmr_rst), .adc_start(adc_start)
  );

  function automatic bit live(input logic [3:0] m);
    return (m >= 4'h8) && (m <= 4'hB);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // advance the model by one edge using the inputs now applied
  task automatic model_edge();
    bit eq, ev, hit;
    eq  = (tmr_val == m_val);
    ev  = eq && !m_eqp;
    hit = ev && live(m_mode);
    m_tr  = hit && (m_mode == 4'hB);
    m_adc = m_tr && adc_en;
    if (hit) m_flag = 1'b1;
    else if (flag_clr) m_flag = 1'b0;
    if (mode_wr) begin
      if (mode_data == 4'h8) m_pin = 1'b0;
      else if (mode_data == 4'h9) m_pin = 1'b1;
    end else if (hit && pin_oe) begin
      if (m_mode == 4'h8) m_pin = 1'b1;
      else if (m_mode == 4'h9) m_pin = 1'b0;
    end
    m_eqp = eq;
    if (val_wr)  m_val  = val_data;
    if (mode_wr) m_mode = mode_data;
  endtask

  task automatic step();
    model_edge();
    @(posedge clk); #1;
    check(cmp_pin,   m_pin,  "R3/R4/R10/R11 pin R3 R4 R10 R11");
    check(irq_flag,  m_flag, "R9 flag");
    check(tmr_rst,   m_tr,   "R6 timer clear");
    check(adc_start, m_adc,  "R7 adc start");
    @(negedge clk);
    val_wr = 0; mode_wr = 0; flag_clr = 0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode_wr = 1; mode_data = m; step();
  endtask

  task automatic set_val(input logic [15:0] v);
    val_wr = 1; val_data = v; step();
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; val_wr = 0; mode_wr = 0; adc_en = 0; pin_oe = 1; flag_clr = 0;
    val_data = 0; mode_data = 0; tmr_val = 16'h0005;
    m_val = 0; m_mode = 0; m_eqp = 0; m_pin = 0; m_flag = 0; m_tr = 0; m_adc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(cmp_pin, 1'b0, "R1 pin");
    check(irq_flag, 1'b0, "R1 flag");
    check(tmr_rst, 1'b0, "R1 tmr_rst");
    check(adc_start, 1'b0, "R1 adc_start");
    rst_n = 1;
    step();

    // R3 drive high
    set_val(16'd100);
    set_mode(4'h8);
    check(cmp_pin, 1'b0, "R11 init low");
    tmr_val = 16'd100; step();
    check(cmp_pin, 1'b1, "R3 pin high");
    // R2 held equal: clear flag, no new event
    flag_clr = 1; step();
    step();
    check(irq_flag, 1'b0, "R2 no repeat event");

    // R4 drive low
    tmr_val = 16'd7; set_mode(4'h9);
    check(cmp_pin, 1'b1, "R11 init high");
    tmr_val = 16'd100; step();
    check(cmp_pin, 1'b0, "R4 pin low");

    // R5 software interrupt, pin unchanged
    tmr_val = 16'd1; flag_clr = 1; set_mode(4'hA);
    tmr_val = 16'd100; step();
    check(irq_flag, 1'b1, "R5 flag set");
    check(cmp_pin, 1'b0, "R5 pin unchanged");

    // R6/R7 special event, adc gated
    tmr_val = 16'd1; set_mode(4'hB);
    adc_en = 1; tmr_val = 16'd100; step();
    check(tmr_rst, 1'b1, "R6 pulse");
    check(adc_start, 1'b1, "R7 adc with enable");
    tmr_val = 16'd0; step();
    check(tmr_rst, 1'b0, "R6 single cycle");
    adc_en = 0; tmr_val = 16'd100; step();
    check(adc_start, 1'b0, "R7 adc gated off");

    // R9 clear and match together
    tmr_val = 16'd2; flag_clr = 1; step();
    tmr_val = 16'd100; flag_clr = 1; step();
    check(irq_flag, 1'b1, "R9 set wins over clear");

    // R8 disabled mode
    tmr_val = 16'd2; flag_clr = 1; set_mode(4'h3);
    tmr_val = 16'd100; step();
    check(irq_flag, 1'b0, "R8 no flag");
    check(tmr_rst, 1'b0, "R8 no trigger");

    // R10 oe low
    tmr_val = 16'd2; set_mode(4'h8);
    pin_oe = 0; tmr_val = 16'd100; step();
    check(cmp_pin, 1'b0, "R10 pin held");
    pin_oe = 1;

    // R11 mode write collides with match
    tmr_val = 16'd2; step();
    tmr_val = 16'd100; mode_wr = 1; mode_data = 4'h9; step();
    check(cmp_pin, 1'b1, "R11 mode write wins");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 5) tmr_val = m_val;
      else if (r < 7) tmr_val = m_val + 16'd1;
      else tmr_val = 16'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        val_wr = 1;
        val_data = ($urandom_range(0, 1) == 0) ? tmr_val : 16'($urandom);
      end
      if ($urandom_range(0, 11) == 0) begin
        mode_wr = 1;
        mode_data = ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'(8 + $urandom_range(0, 3));
      end
      adc_en   = 1'($urandom);
      pin_oe   = ($urandom_range(0, 3) != 0);
      flag_clr = ($urandom_range(0, 2) == 0);
      step();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule